// File: doc/BRIEF.md
# One-Shot Countdown Event Timer

This block is a memory-mapped event timer that fires once per programmed interval. Software turns the timer on, writes a tick count into the timeout register, and then sets the interrupt enable. Writing the timeout register starts the countdown; there is no separate start bit. Every cycle in which `tick_en` is high, the count drops by one. When the count runs out, the timer stops, latches a pending flag and drives a level interrupt. The interrupt stays high until software writes the clear strobe. Callers normally program at least 3 ticks.

Two registers are exposed through a single-cycle write port and a combinational read port. Changes to the timeout value and to the interrupt controls are accepted only while the timer is already on. Writing zero to the control register switches the whole block off.

The sequencing lives in a three-state machine:
- `ST_OFF`: clock enable cleared.
- `ST_IDLE`: enabled, not counting.
- `ST_RUN`: counting down.

Its transitions are:
- `ST_OFF`→`ST_IDLE` on a control write with the enable bit set.
- `ST_IDLE`→`ST_RUN` on an accepted timeout write.
- `ST_RUN`→`ST_RUN` when an accepted timeout write restarts the countdown.
- `ST_RUN`→`ST_IDLE` on expiry.
- `ST_IDLE`/`ST_RUN`→`ST_OFF` on a control write with the enable bit clear.

Top module: `cdt_timer`

## Requirements
- R1: After reset, the control register reads 0, the timeout register reads 0 and `irq_o` is low.
- R2: The control register is at offset 0x40, with bit 0 = timer enable, bit 1 = interrupt enable and bit 4 = clear strobe, which always reads 0. The timeout register is at offset 0x44 and reads the remaining count. Any other offset reads 0.
- R3: A timeout write accepted while enabled loads the count and starts the countdown. It leaves the pending flag unchanged.
- R4: Each cycle in `ST_RUN` with `tick_en` high lowers the count by 1. The tick that finds the count at 1 or 0 sets the count to 0, sets pending and stops counting. So a load of N expires after max(N,1) ticks.
- R5: `irq_o` is high exactly when pending and interrupt enable are both set. It stays high until a control write changes one of them.
- R6: A timeout write while the timer is off is ignored. The count, pending and `irq_o` are unchanged, and no countdown starts.
- R7: A control write with bit 0 set while the timer is off only turns the timer on. Bits 1 and 4 of that write are ignored.
- R8: A control write with bit 0 set while the timer is on copies bit 1 into the interrupt enable, and clears pending if bit 4 is set. Writing 0x11 therefore clears the pending interrupt and disables further interrupts.
- R9: A control write with bit 0 clear turns the timer off. It clears the interrupt enable and pending, halts counting, and holds the count.
- R10: A timeout write in the same cycle as a tick takes priority: the new value is loaded and not decremented.
- R11: When expiry and a clear strobe land in the same cycle, pending ends up set.
- R12: While `tick_en` is low the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Countdown tick qualifier |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong internal state shows up at the ports on the next cycle after the event. A wrong state-machine state or count appears in the timeout register readback right away. A wrong pending flag or interrupt enable appears on `irq_o` or in control bit 1. For this reason the bench sweeps every load value from 0 to 12 and reads the count and `irq_o` after every tick, rather than only at the end. It also applies all 32 control encodings to an expired, interrupt-enabled timer and checks the resulting enable bits and interrupt one cycle later.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_RUN  = 2'd2
    } cdt_state_e;

    localparam int BIT_EN  = 0;
    localparam int BIT_IEN = 1;
    localparam int BIT_CLR = 4;
endpackage

// File: rtl/cdt_regif.sv
module cdt_regif #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 'h40,
    parameter logic [ADDR_W-1:0] VAL_OFF  = 'h44
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              w_en_bit,
    input  logic              enabled,
    input  logic              irq_en,
    input  logic [DATA_W-1:0] count,
    output logic              en_on,
    output logic              ctrl_upd,
    output logic              ctrl_off,
    output logic              val_load,
    output logic [DATA_W-1:0] bus_rdata
);
    import cdt_pkg::*;

    logic ctrl_wr;
    logic val_wr;

    always_comb begin
        ctrl_wr  = bus_wr && (bus_addr == CTRL_OFF);
        val_wr   = bus_wr && (bus_addr == VAL_OFF);
        en_on    = ctrl_wr && w_en_bit && !enabled;
        ctrl_upd = ctrl_wr && w_en_bit && enabled;
        ctrl_off = ctrl_wr && !w_en_bit;
        val_load = val_wr && enabled;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_OFF) begin
            bus_rdata[BIT_EN]  = enabled;
            bus_rdata[BIT_IEN] = irq_en;
        end else if (bus_addr == VAL_OFF) begin
            bus_rdata = count;
        end
    end
endmodule

// File: rtl/cdt_fsm.sv
module cdt_fsm #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en_on,
    input  logic              ctrl_off,
    input  logic              val_load,
    input  logic [DATA_W-1:0] load_val,
    output logic              enabled,
    output logic              expire,
    output logic [DATA_W-1:0] count
);
    import cdt_pkg::*;

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    cdt_state_e state_q, state_d;
    logic [DATA_W-1:0] count_d;
    logic last_tick;

    assign last_tick = (count <= ONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_on) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (ctrl_off)      state_d = ST_OFF;
                else if (val_load) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (ctrl_off)               state_d = ST_OFF;
                else if (val_load)          state_d = ST_RUN;
                else if (tick && last_tick) state_d = ST_IDLE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        enabled = (state_q != ST_OFF);
        expire  = (state_q == ST_RUN) && tick && !val_load && !ctrl_off && last_tick;
        count_d = count;
        if (val_load)
            count_d = load_val;
        else if ((state_q == ST_RUN) && tick && !ctrl_off)
            count_d = last_tick ? '0 : count - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count_d;
    end

    a_r12_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !val_load) |=> $stable(count));
    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick && !val_load && !ctrl_off && count > ONE)
        |=> count == $past(count) - ONE);
    a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (state_q == ST_IDLE && count == '0));
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        val_load |=> (count == $past(load_val) && state_q == ST_RUN));
    a_r9_off: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_off |=> (state_q == ST_OFF && $stable(count)));
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_upd,
    input  logic ctrl_off,
    input  logic w_ien_bit,
    input  logic w_clr_bit,
    input  logic expire,
    output logic irq_en,
    output logic pending,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en  <= 1'b0;
            pending <= 1'b0;
        end else if (ctrl_off) begin
            irq_en  <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (ctrl_upd) irq_en <= w_ien_bit;
            if (expire)                      pending <= 1'b1;
            else if (ctrl_upd && w_clr_bit)  pending <= 1'b0;
        end
    end

    assign irq = pending && irq_en;

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pending);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_upd && w_clr_bit && !expire) |=> !pending);
    a_r9_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_off |=> (!irq_en && !pending));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 'h40,
    parameter logic [ADDR_W-1:0] VAL_OFF  = 'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    import cdt_pkg::*;

    logic en_on, ctrl_upd, ctrl_off, val_load;
    logic enabled, expire, irq_en, pending;
    logic [DATA_W-1:0] count;

    cdt_regif #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFF(CTRL_OFF), .VAL_OFF(VAL_OFF)
    ) u_regif (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .w_en_bit (bus_wdata[BIT_EN]),
        .enabled  (enabled),
        .irq_en   (irq_en),
        .count    (count),
        .en_on    (en_on),
        .ctrl_upd (ctrl_upd),
        .ctrl_off (ctrl_off),
        .val_load (val_load),
        .bus_rdata(bus_rdata)
    );

    cdt_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .en_on   (en_on),
        .ctrl_off(ctrl_off),
        .val_load(val_load),
        .load_val(bus_wdata),
        .enabled (enabled),
        .expire  (expire),
        .count   (count)
    );

    cdt_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_upd (ctrl_upd),
        .ctrl_off (ctrl_off),
        .w_ien_bit(bus_wdata[BIT_IEN]),
        .w_clr_bit(bus_wdata[BIT_CLR]),
        .expire   (expire),
        .irq_en   (irq_en),
        .pending  (pending),
        .irq      (irq_o)
    );

    a_r6_ignored_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == VAL_OFF && !enabled) |=> ($stable(count) && $stable(pending)));
    a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(bus_wr && bus_addr == CTRL_OFF)) |=> irq_o);
    a_r7_enable_only: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTRL_OFF && bus_wdata[BIT_EN] && !enabled)
        |=> (!irq_en && $stable(pending)));
endmodule

// File: tb/cdt_timer_test.sv
module cdt_timer_test;
    localparam int CLK_P = 10;
    localparam logic [7:0] A_CTRL = 8'h40;
    localparam logic [7:0] A_VAL  = 8'h44;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    cdt_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge with the write applied
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, r); chk("R1 ctrl", r, 0);
        rd(A_VAL, r);  chk("R1 value", r, 0);
        chk("R1 irq", irq_o, 0);
        // R2 unmapped offset
        rd(8'h48, r); chk("R2 unmapped", r, 0);

        // R6 value write while off is ignored
        wr(A_VAL, 32'h55);
        rd(A_VAL, r); chk("R6 count unchanged", r, 0);
        // R7 enable write ignores irq-enable/clear bits
        wr(A_CTRL, 32'h13);
        rd(A_CTRL, r); chk("R7 only enable", r, 32'h1);
        wr(A_CTRL, 32'h3);
        rd(A_CTRL, r); chk("R2 ctrl fields", r, 32'h3);
        ticks(5);
        rd(A_VAL, r); chk("R6 no countdown started", r, 0);
        chk("R6 no irq", irq_o, 0);

        // R3 R4 R5 sweep of load values
        for (int n = 0; n <= 12; n++) begin
            int fire;
            fire = (n < 1) ? 1 : n;
            wr(A_VAL, n);
            rd(A_VAL, r); chk("R3 load", r, n);
            chk("R3 pending not set by load", irq_o, 0);
            tick_en = 1'b1;
            for (int k = 1; k <= n + 2; k++) begin
                @(negedge clk);
                rd(A_VAL, r);
                chk("R4 count", r, (k < n) ? (n - k) : 0);
                chk("R5 irq level", irq_o, (k >= fire) ? 1 : 0);
            end
            tick_en = 1'b0;
            wr(A_CTRL, 32'h13);
            chk("R8 clear strobe", irq_o, 0);
            rd(A_CTRL, r); chk("R2 clear reads 0", r, 32'h3);
        end

        // R12 hold while tick low
        wr(A_VAL, 10);
        ticks(3);
        repeat (4) @(negedge clk);
        rd(A_VAL, r); chk("R12 hold", r, 7);

        // R10 load wins over tick
        tick_en = 1'b1;
        wr(A_VAL, 20);
        rd(A_VAL, r); chk("R10 load wins", r, 20);
        @(negedge clk);
        rd(A_VAL, r); chk("R10 resumes", r, 19);
        tick_en = 1'b0;

        // R11 expiry and clear in the same cycle
        wr(A_VAL, 1);
        tick_en = 1'b1;
        wr(A_CTRL, 32'h13);
        tick_en = 1'b0;
        chk("R11 set wins", irq_o, 1);
        wr(A_CTRL, 32'h13);
        chk("R11 later clear", irq_o, 0);

        // R3 load keeps pending; R9 disable
        wr(A_VAL, 0);
        ticks(1);
        chk("R5 irq after expiry", irq_o, 1);
        wr(A_VAL, 9);
        chk("R3 load keeps pending", irq_o, 1);
        ticks(2);
        wr(A_CTRL, 32'h0);
        chk("R9 irq off", irq_o, 0);
        rd(A_CTRL, r); chk("R9 ctrl off", r, 0);
        ticks(3);
        rd(A_VAL, r); chk("R9 count held", r, 7);
        wr(A_CTRL, 32'h1);
        wr(A_CTRL, 32'h3);
        chk("R9 pending cleared", irq_o, 0);

        // R8 sweep of all control encodings from an expired, irq-enabled state
        for (int w = 0; w < 32; w++) begin
            logic en, ien, pend;
            wr(A_CTRL, 32'h1);
            wr(A_CTRL, 32'h3);
            wr(A_VAL, 0);
            ticks(1);
            wr(A_CTRL, w);
            en   = w[0];
            ien  = w[0] & w[1];
            pend = w[0] & ~w[4];
            rd(A_CTRL, r); chk("R8 ctrl readback", r, {30'b0, ien, en});
            chk("R8 irq", irq_o, ien & pend);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule